// File: doc/BRIEF.md
# Latched serial-to-parallel shift register

This block takes a serial bit stream into a chain of flip-flops and holds a separately updated copy of that chain on a parallel output. Two strobe pins, one for shifting and one for storing, arrive from outside the chip. Each pin passes through a two-flop synchronizer into the system clock domain. A rising edge on a pin turns into a single-cycle internal pulse. A shift pulse moves the serial input into the first stage and pushes every other stage one position along. A store pulse copies the whole chain into a holding register that drives the parallel data outputs.

The last stage is brought out as a serial output, so several blocks can be chained by wiring one block's serial output to the next block's serial input and sharing the strobes. An active-low clear asynchronously zeroes the chain only. An active-low output enable controls a per-bit drive vector next to the parallel data. A wrapper at the pads can turn that pair into a tri-state bus. The enable never alters stored state. A system reset clears both registers at power-up.

Top module: `latched_sipo`

## Requirements
- R1: On each shift pulse, stage 0 of the chain takes `ser_in`, and each stage k (k ≥ 1) takes the previous value of stage k−1. Bits fed in order therefore appear with the earliest one in the highest stage.
- R2: `ser_out` always equals the highest stage of the chain, whatever the value of `oe_n`. A second block whose `ser_in` is driven by `ser_out` and that shares the strobes extends the chain to twice the width.
- R3: A store pulse copies every stage of the chain into the storage register at once. `par_data[k]` shows chain stage k from then until the next store pulse.
- R4: While `clear_n` is low, the chain is all zeros, with no clock edge needed, and `ser_out` is 0. `par_data` keeps its previous value.
- R5: A store pulse while `clear_n` is held low loads all zeros into `par_data`.
- R6: `par_oe` is all ones (bit = 1 means driven) while `oe_n` is low, and all zeros (high impedance) while `oe_n` is high. Changing `oe_n` alters neither the chain nor the storage register.
- R7: When the shift pulse and the store pulse occur in the same cycle, the storage register captures the chain as it was before that shift.
- R8: While `rst_n` is low, both the chain and the storage register are zero, so `par_data` = 0 and `ser_out` = 0.
- R9: Each rising edge on `shift_pin` or `store_pin` produces exactly one pulse of the matching action, however long the pin then stays high. The action takes effect within 4 system clocks of the pin rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, clears both registers |
| shift_pin | input | 1 | Shift strobe, asynchronous, acts on its rising edge |
| store_pin | input | 1 | Store strobe, asynchronous, acts on its rising edge |
| clear_n | input | 1 | Active-low asynchronous clear of the shift chain |
| oe_n | input | 1 | Active-low output enable for the parallel outputs |
| ser_in | input | 1 | Serial data input |
| par_data | output | W | Storage register contents |
| par_oe | output | W | Per-bit drive enable for par_data, 1 = driven |
| ser_out | output | 1 | Highest chain stage, for chaining |

## Verification
Two blocks are chained, and a sweep of 16-bit words is shifted through them and stored. A wrong shift direction or a lost cross-block bit would scramble the high and low bytes against the reference word. Strobes are raised together to check that the store captures the chain from before the shift. A design that let the shift win would show a result one bit ahead. The clear is exercised alone and together with a store. A clear that touched the storage register would blank `par_data` early, and one that did not clear the chain would store stale data. A strobe held high for a long time checks that only one action happens per edge. A level-sensitive detector would shift again on every cycle and flood the chain with copies of `ser_in`.

// File: rtl/latched_sipo_pkg.sv
package latched_sipo_pkg;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned STROBE_NUM = 2;
  localparam int unsigned IDX_SHIFT  = 0;
  localparam int unsigned IDX_STORE  = 1;

  function automatic logic rise_det(input logic prev, input logic cur);
    return cur & ~prev;
  endfunction
endpackage

// File: rtl/sipo_edge_sync.sv
module sipo_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pulse
);
  import latched_sipo_pkg::*;

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign pulse = rise_det(last_q, sync_q[STAGES-1]);
endmodule

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_n,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic [W-1:0] chain_q
);
  function automatic logic [W-1:0] shift_next(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  logic chain_rst_n;
  assign chain_rst_n = rst_n & clear_n;

  always_ff @(posedge clk or negedge chain_rst_n) begin
    if (!chain_rst_n) chain_q <= '0;
    else if (shift_en) chain_q <= shift_next(chain_q, ser_in);
  end
endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/latched_sipo.sv
module latched_sipo #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_pin,
  input  logic         store_pin,
  input  logic         clear_n,
  input  logic         oe_n,
  input  logic         ser_in,
  output logic [W-1:0] par_data,
  output logic [W-1:0] par_oe,
  output logic         ser_out
);
  import latched_sipo_pkg::*;

  function automatic logic [W-1:0] drive_mask(input logic en_n);
    return {W{~en_n}};
  endfunction

  logic [STROBE_NUM-1:0] pins;
  logic [STROBE_NUM-1:0] pulses;
  logic                  shift_pulse;
  logic                  store_pulse;
  logic [W-1:0]          chain_q;

  assign pins[IDX_SHIFT] = shift_pin;
  assign pins[IDX_STORE] = store_pin;

  for (genvar g = 0; g < STROBE_NUM; g++) begin : g_sync
    sipo_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (pins[g]),
      .pulse (pulses[g])
    );
  end

  assign shift_pulse = pulses[IDX_SHIFT];
  assign store_pulse = pulses[IDX_STORE];

  sipo_shift_chain #(.W(W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_n  (clear_n),
    .shift_en (shift_pulse),
    .ser_in   (ser_in),
    .chain_q  (chain_q)
  );

  sipo_store_reg #(.W(W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (store_pulse),
    .d     (chain_q),
    .q     (par_data)
  );

  assign ser_out = chain_q[W-1];
  assign par_oe  = drive_mask(oe_n);
endmodule

// File: rtl/latched_sipo_chk.sv
module latched_sipo_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear_n,
  input logic         oe_n,
  input logic         ser_in,
  input logic         shift_pulse,
  input logic         store_pulse,
  input logic [W-1:0] chain_q,
  input logic [W-1:0] par_data,
  input logic [W-1:0] par_oe,
  input logic         ser_out
);
  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_pulse && clear_n) |=> (!clear_n || chain_q[0] == $past(ser_in)));

  // R2
  ser_out_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_pulse && clear_n) |=> (!clear_n || ser_out == $past(chain_q[W-2])));

  // R3
  store_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_pulse |=> (par_data == $past(chain_q)));

  // R4
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !store_pulse |=> $stable(par_data));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |-> (chain_q == '0 && !ser_out));

  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (par_oe == '0));

  // R6
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (&par_oe));

  // R9
  shift_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> !shift_pulse);

  // R9
  store_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_pulse |=> !store_pulse);
endmodule

bind latched_sipo latched_sipo_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clear_n     (clear_n),
  .oe_n        (oe_n),
  .ser_in      (ser_in),
  .shift_pulse (shift_pulse),
  .store_pulse (store_pulse),
  .chain_q     (chain_q),
  .par_data    (par_data),
  .par_oe      (par_oe),
  .ser_out     (ser_out)
);

// File: tb/latched_sipo_tb.sv
`timescale 1ns/1ps
module latched_sipo_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, shift_pin, store_pin, clear_n, oe_n, ser_in;
  logic [W-1:0] pd_a, po_a, pd_b, po_b;
  logic so_a, so_b;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  latched_sipo #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .shift_pin(shift_pin), .store_pin(store_pin),
    .clear_n(clear_n), .oe_n(oe_n), .ser_in(ser_in),
    .par_data(pd_a), .par_oe(po_a), .ser_out(so_a)
  );

  latched_sipo #(.W(W)) u_nxt (
    .clk(clk), .rst_n(rst_n), .shift_pin(shift_pin), .store_pin(store_pin),
    .clear_n(clear_n), .oe_n(oe_n), .ser_in(so_a),
    .par_data(pd_b), .par_oe(po_b), .ser_out(so_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(input logic sh, input logic st);
    shift_pin = sh;
    store_pin = st;
    tick(4);
    shift_pin = 1'b0;
    store_pin = 1'b0;
    tick(4);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int b = 15; b >= 0; b--) begin
      ser_in = w[b];
      strobe(1'b1, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [W-1:0] held;
    rst_n = 1'b0; shift_pin = 1'b0; store_pin = 1'b0;
    clear_n = 1'b1; oe_n = 1'b0; ser_in = 1'b0;
    tick(3);
    // R8 reset state
    chk("R8 reset par_data", {24'd0, pd_a}, 32'd0);
    chk("R8 reset ser_out", {31'd0, so_a}, 32'd0);
    chk("R6 par_oe enabled", {24'd0, po_a}, {24'd0, {W{1'b1}}});
    rst_n = 1'b1;
    tick(2);

    // R1 R2 R3 sweep over two chained blocks
    for (int i = 0; i < 160; i++) begin
      w = 16'(i * 16'h9E37) ^ 16'(i << 5);
      if (i == 1) w = 16'hFFFF;
      if (i == 2) w = 16'h8001;
      send_word(w);
      if (so_b !== w[15]) chk("R2 ser_out chained", {31'd0, so_b}, {31'd0, w[15]});
      else checks++;
      strobe(1'b0, 1'b1);
      if (pd_a !== w[7:0] || pd_b !== w[15:8])
        chk("R3 R1 stored word", {16'd0, pd_b, pd_a}, {16'd0, w});
      else checks++;
    end
    chk("R2 ser_out last", {31'd0, so_a}, {31'd0, w[7]});

    // R6 output enable gates drive only
    held = pd_a;
    oe_n = 1'b1;
    tick(2);
    chk("R6 par_oe off", {24'd0, po_a}, 32'd0);
    chk("R6 data held while off", {24'd0, pd_a}, {24'd0, held});
    chk("R2 ser_out not gated", {31'd0, so_a}, {31'd0, w[7]});
    ser_in = 1'b1;
    strobe(1'b1, 1'b0);
    chk("R2 ser_out shifts while off", {31'd0, so_a}, {31'd0, w[6]});
    oe_n = 1'b0;
    tick(1);
    chk("R6 data after re-enable", {24'd0, pd_a}, {24'd0, held});

    // R7 simultaneous strobes: chain is {w[6:0],1}
    ser_in = 1'b0;
    strobe(1'b1, 1'b1);
    chk("R7 store pre-shift", {24'd0, pd_a}, {24'd0, w[6:0], 1'b1});
    strobe(1'b0, 1'b1);
    chk("R7 next store post-shift", {24'd0, pd_a}, {24'd0, w[5:0], 2'b10});

    // R9 long pin pulse gives one shift
    send_word(16'h0000);
    ser_in = 1'b1;
    shift_pin = 1'b1;
    tick(20);
    shift_pin = 1'b0;
    tick(4);
    ser_in = 1'b0;
    strobe(1'b0, 1'b1);
    chk("R9 one shift per edge", {24'd0, pd_a}, 32'd1);

    // R4 clear affects chain only
    send_word(16'h00A5);
    strobe(1'b0, 1'b1);
    chk("R3 stored A5", {24'd0, pd_a}, 32'hA5);
    clear_n = 1'b0;
    #1;
    chk("R4 ser_out cleared", {31'd0, so_a}, 32'd0);
    tick(3);
    chk("R4 par_data kept", {24'd0, pd_a}, 32'hA5);
    // R5 store during clear
    strobe(1'b0, 1'b1);
    chk("R5 store zeros", {16'd0, pd_b, pd_a}, 32'd0);
    clear_n = 1'b1;
    tick(2);

    // R8 system reset clears both registers
    send_word(16'hC3C3);
    strobe(1'b0, 1'b1);
    rst_n = 1'b0;
    tick(2);
    chk("R8 reset clears store", {16'd0, pd_b, pd_a}, 32'd0);
    chk("R8 reset clears chain", {31'd0, so_a}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule